// File: doc/BRIEF.md
# Privileged Performance Counter Bank

This block holds a set of generic event counters. Each counter has a configuration register and a data register. Software reaches both through a single request port. The port carries a space select (configuration or data), an 8-bit register index, a write flag and write data. Every request also carries the requester's current privilege level (0 is the most privileged, 3 the least) and a secure-monitoring status bit.

The implemented pairs occupy indices 4 up to a parameterised last index in both spaces. Any other index behaves as an empty slot. The access rules are as follows:

- Configuration reads, configuration writes and data writes are reserved for level 0. At any other level they raise a fault.
- Data reads are open to every level.
- When the secure-monitoring bit is set, an unprivileged data read returns zero instead of the count.

Each counter watches one line of a 256-line event bus. It counts only while the current privilege level is enabled in its own 4-bit level mask.

Top module: `perf_counter_bank`

## Requirements
- R1: Counter pairs exist at indices 4 through LAST_IDX (default 7), and configuration index i and data index i address the same counter, so the pair at LAST_IDX is fully usable.
- R2: A level-0 configuration read returns the stored event select in bits [7:0] and the level mask in bits [11:8], with all other bits zero.
- R3: A read of any index outside 4..LAST_IDX, in either space, returns zero. A write to such an index changes no counter and no configuration.
- R4: A configuration write, data write or configuration read made at a level other than 0 pulses `priv_fault` in the same cycle, whatever the index. It produces no read response and changes no state.
- R5: A data read made at a level other than 0 raises no fault. It returns zero when `secure_mon` is 1 and the current count when `secure_mon` is 0.
- R6: A counter increments by one in a cycle only when `event_bus[select]` is 1 and bit `priv_lvl` of its level mask is 1. Otherwise it holds.
- R7: A level-0 data read returns the counter value, zero-extended to 64 bits.
- R8: A counter at all ones that increments wraps to zero and sets its sticky bit in `ovf_flags` (bit k for index 4+k). The bit stays set.
- R9: A level-0 write to a data register loads the low CNT_W bits of the write data and clears that counter's overflow bit.
- R10: When a level-0 data write and a qualifying event fall in the same cycle, the written value is stored and the event is not counted.
- R11: An accepted read gives `rd_valid` = 1 with its data exactly one cycle after the request. In every other cycle `rd_valid` is 0 and `rd_data` is zero. After reset, all counters, masks, selects and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = configuration space, 1 = data space |
| req_idx | input | 8 | Register index 0..255 |
| req_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level (also used for event filtering) |
| secure_mon | input | 1 | Secure-monitoring status bit |
| event_bus | input | 256 | Event lines, one per select code |
| priv_fault | output | 1 | Privileged-operation fault, same cycle as the request |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| ovf_flags | output | LAST_IDX-3 | Sticky overflow flag per counter |

## Verification
The hardest cases to reach from the ports are the collisions. One is a counter sitting at all ones when an event arrives. The other is a data write landing in the same cycle as a qualifying event. The stimulus preloads a counter to two below wrap with a level-0 write. It then holds the selected event line high so that the wrap and the sticky flag land on known cycles. A later write is issued with the event still active, so the write and the increment collide in a single cycle.

A reference model in the bench tracks every counter cycle by cycle. A long run of mixed-privilege, mixed-index requests over random event traffic is then compared against it on every clock.

// File: rtl/pcb_pkg.sv
// Package: shared field layout and types for the performance counter bank.
// Assumes an 8-bit event select (256 event lines) and four privilege levels.
package pcb_pkg;
    localparam int REG_W     = 64;
    localparam int IDX_W     = 8;
    localparam int SEL_W     = 8;
    localparam int EVT_W     = 1 << SEL_W;
    localparam int PRIV_LVLS = 4;
    localparam int PRIV_W    = $clog2(PRIV_LVLS);
    localparam int FIRST_IDX = 4;
    localparam int CFG_W     = SEL_W + PRIV_LVLS;

    typedef enum logic {
        SPACE_CFG = 1'b0,
        SPACE_DAT = 1'b1
    } reg_space_e;

    typedef struct packed {
        logic [PRIV_LVLS-1:0] lvl_mask;
        logic [SEL_W-1:0]     evt_sel;
    } cnt_cfg_t;
endpackage

// File: rtl/pcb_access_ctrl.sv
// Module: pcb_access_ctrl
// Decodes a register request, applies the privilege rules and produces
// per-counter write strobes and a one-hot read slot. Purely combinational.
// Assumes at most one request per cycle.
module pcb_access_ctrl
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  reg_space_e         req_space,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [PRIV_W-1:0]  priv_lvl,
    input  logic               secure_mon,
    output logic               priv_fault,
    output logic [NUM_CNT-1:0] cfg_we,
    output logic [NUM_CNT-1:0] dat_we,
    output logic [NUM_CNT-1:0] rd_slot,
    output logic               rd_accept,
    output logic               rd_is_dat,
    output logic               rd_blank
);
    logic is_top_lvl;
    logic needs_priv;
    logic hit;
    logic wr_ok;

    // Classify the request against the privilege rules.
    always_comb begin
        is_top_lvl = (priv_lvl == '0);
        needs_priv = req_write || (req_space == SPACE_CFG);
        priv_fault = req_valid && needs_priv && !is_top_lvl;
        wr_ok      = req_valid && req_write && is_top_lvl;
        rd_accept  = req_valid && !req_write && !priv_fault;
        rd_is_dat  = (req_space == SPACE_DAT);
    end

    // One decode line per implemented counter pair.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_dec
        assign rd_slot[k] = (req_idx == IDX_W'(FIRST_IDX + k));
        assign cfg_we[k]  = wr_ok && rd_slot[k] && (req_space == SPACE_CFG);
        assign dat_we[k]  = wr_ok && rd_slot[k] && (req_space == SPACE_DAT);
    end

    // Blank the response for empty slots and for masked unprivileged data reads.
    always_comb begin
        hit      = |rd_slot;
        rd_blank = !hit || (rd_is_dat && !is_top_lvl && secure_mon);
    end

    // R4
    fault_needs_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> (priv_lvl != '0) && req_valid);

    // R4
    fault_blocks_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> (cfg_we == '0) && (dat_we == '0) && !rd_accept);

    // R1
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_slot));
endmodule

// File: rtl/pcb_counter.sv
// Module: pcb_counter
// One counter pair: configuration (event select + level mask), a CNT_W-bit
// wrapping counter and a sticky overflow flag. A data write beats an event
// in the same cycle. Assumes CNT_W <= 64.
module pcb_counter
    import pcb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              dat_we,
    input  logic [CFG_W-1:0]  cfg_wval,
    input  logic [CNT_W-1:0]  dat_wval,
    input  logic [EVT_W-1:0]  event_bus,
    input  logic [PRIV_W-1:0] priv_lvl,
    output cnt_cfg_t          cfg_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              ovf_q
);
    logic evt_line;
    logic inc;
    logic wrap;

    // Event qualification by select and privilege mask.
    always_comb begin
        evt_line = event_bus[cfg_q.evt_sel];
        inc      = evt_line && cfg_q.lvl_mask[priv_lvl];
        wrap     = inc && (&count_q);
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cnt_cfg_t'(cfg_wval);
        end
    end

    // Counter: a write wins, otherwise count qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (dat_we) begin
            count_q <= dat_wval;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Sticky overflow flag: set on wrap, cleared by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (dat_we) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end
    end

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> count_q == $past(dat_wval));

    // R6
    step_at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

    // R8
    ovf_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> ($past(count_q) == '1) && (count_q == '0));

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> !ovf_q);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !dat_we) |=> ovf_q);
endmodule

// File: rtl/pcb_read_mux.sv
// Module: pcb_read_mux
// Selects the addressed configuration or count and registers the response,
// giving a one-cycle read latency. Non-responses drive zero data.
module pcb_read_mux
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_accept,
    input  logic                            rd_is_dat,
    input  logic                            rd_blank,
    input  logic [NUM_CNT-1:0]              rd_slot,
    input  cnt_cfg_t [NUM_CNT-1:0]          cfg_all,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
    output logic                            rd_valid,
    output logic [REG_W-1:0]                rd_data
);
    logic [REG_W-1:0] sel_word;

    // One-hot OR mux over the implemented pairs.
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (rd_slot[k]) begin
                sel_word = sel_word | (rd_is_dat ? REG_W'(cnt_all[k])
                                                 : REG_W'(cfg_all[k]));
            end
        end
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_accept;
            rd_data  <= (rd_accept && !rd_blank) ? sel_word : '0;
        end
    end

    // R11
    rd_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_accept));

    // R11
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/perf_counter_bank.sv
// Module: perf_counter_bank (top)
// Bank of privileged performance counter pairs at indices 4..LAST_IDX.
// Assumes 7 <= LAST_IDX <= 255 and CNT_W <= 64; one request per cycle.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int LAST_IDX = 7,
    parameter int CNT_W    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_space,
    input  logic [7:0]              req_idx,
    input  logic [63:0]             req_wdata,
    input  logic [1:0]              priv_lvl,
    input  logic                    secure_mon,
    input  logic [255:0]            event_bus,
    output logic                    priv_fault,
    output logic                    rd_valid,
    output logic [63:0]             rd_data,
    output logic [LAST_IDX-4:0]     ovf_flags
);
    localparam int NUM_CNT = LAST_IDX - FIRST_IDX + 1;

    reg_space_e                    space;
    logic [NUM_CNT-1:0]            cfg_we;
    logic [NUM_CNT-1:0]            dat_we;
    logic [NUM_CNT-1:0]            rd_slot;
    logic                          rd_accept;
    logic                          rd_is_dat;
    logic                          rd_blank;
    cnt_cfg_t [NUM_CNT-1:0]        cfg_all;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic                          unused_wdata;

    assign space        = reg_space_e'(req_space);
    assign unused_wdata = ^req_wdata;

    pcb_access_ctrl #(.NUM_CNT(NUM_CNT)) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_space  (space),
        .req_idx    (req_idx),
        .priv_lvl   (priv_lvl),
        .secure_mon (secure_mon),
        .priv_fault (priv_fault),
        .cfg_we     (cfg_we),
        .dat_we     (dat_we),
        .rd_slot    (rd_slot),
        .rd_accept  (rd_accept),
        .rd_is_dat  (rd_is_dat),
        .rd_blank   (rd_blank)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        pcb_counter #(.CNT_W(CNT_W)) u_counter (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[k]),
            .dat_we    (dat_we[k]),
            .cfg_wval  (req_wdata[CFG_W-1:0]),
            .dat_wval  (req_wdata[CNT_W-1:0]),
            .event_bus (event_bus),
            .priv_lvl  (priv_lvl),
            .cfg_q     (cfg_all[k]),
            .count_q   (cnt_all[k]),
            .ovf_q     (ovf_flags[k])
        );
    end

    pcb_read_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (rd_accept),
        .rd_is_dat (rd_is_dat),
        .rd_blank  (rd_blank),
        .rd_slot   (rd_slot),
        .cfg_all   (cfg_all),
        .cnt_all   (cnt_all),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R5
    secure_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_space && (priv_lvl != 2'd0) && secure_mon)
        |=> rd_valid && (rd_data == '0));

    // R5
    unpriv_data_read_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_space) |-> !priv_fault);

    // R3
    empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !priv_fault &&
         ((req_idx < 8'(FIRST_IDX)) || (int'(req_idx) > LAST_IDX)))
        |=> rd_valid && (rd_data == '0));

    // R4
    fault_no_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |=> !rd_valid);

    // R4
    fault_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_fault && ovf_flags == '0 && event_bus == '0) |=> ovf_flags == '0);
endmodule

// File: tb/perf_counter_bank_bench.sv
// Bench: cycle-by-cycle behavioural model of the counter bank, compared on every clock.
module perf_counter_bank_bench;
    localparam int NC = 4;
    localparam int LAST = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_space = 1'b0;
    logic [7:0]   req_idx = '0;
    logic [63:0]  req_wdata = '0;
    logic [1:0]   priv_lvl = '0;
    logic         secure_mon = 1'b0;
    logic [255:0] event_bus = '0;
    logic         priv_fault, rd_valid;
    logic [63:0]  rd_data;
    logic [NC-1:0] ovf_flags;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag_ovr = "";

    logic [7:0]  m_sel [NC];
    logic [3:0]  m_mask[NC];
    logic [31:0] m_cnt [NC];
    logic        m_ovf [NC];
    logic        exp_v;
    logic [63:0] exp_d;
    string       exp_tag;

    always #4 clk = ~clk;

    perf_counter_bank #(.LAST_IDX(LAST), .CNT_W(32)) u_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_idx(req_idx), .req_wdata(req_wdata),
        .priv_lvl(priv_lvl), .secure_mon(secure_mon), .event_bus(event_bus),
        .priv_fault(priv_fault), .rd_valid(rd_valid), .rd_data(rd_data),
        .ovf_flags(ovf_flags)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: check fault, advance model at the edge, check registered outputs.
    task automatic tick();
        logic ef, hit, inc;
        int slot;
        #1;
        ef = req_valid && (req_write || !req_space) && (priv_lvl != 2'd0);
        chk("R4", 64'(priv_fault), 64'(ef));
        @(posedge clk);
        slot = int'(req_idx) - 4;
        hit = (slot >= 0) && (slot < NC);
        if (!rst_n) begin
            for (int k = 0; k < NC; k++) begin
                m_sel[k] = '0; m_mask[k] = '0; m_cnt[k] = '0; m_ovf[k] = 0;
            end
            exp_v = 0; exp_d = '0; exp_tag = "R11";
        end else begin
            exp_v = req_valid && !req_write && !ef;
            exp_d = '0;
            exp_tag = "R11";
            if (exp_v) begin
                if (!hit) exp_tag = "R3";
                else if (!req_space) begin
                    exp_tag = (int'(req_idx) == LAST) ? "R1" : "R2";
                    exp_d = {52'd0, m_mask[slot], m_sel[slot]};
                end else if (priv_lvl != 2'd0) begin
                    exp_tag = "R5";
                    exp_d = secure_mon ? 64'd0 : {32'd0, m_cnt[slot]};
                end else begin
                    exp_tag = "R7";
                    exp_d = {32'd0, m_cnt[slot]};
                end
            end
            if (tag_ovr != "") exp_tag = tag_ovr;
            for (int k = 0; k < NC; k++) begin
                inc = event_bus[m_sel[k]] && m_mask[k][priv_lvl];
                if (req_valid && req_write && req_space && priv_lvl == 0 && slot == k) begin
                    m_cnt[k] = req_wdata[31:0];
                    m_ovf[k] = 0;
                end else if (inc) begin
                    if (m_cnt[k] == 32'hFFFF_FFFF) m_ovf[k] = 1;
                    m_cnt[k] = m_cnt[k] + 1;
                end
                if (req_valid && req_write && !req_space && priv_lvl == 0 && slot == k) begin
                    m_sel[k] = req_wdata[7:0];
                    m_mask[k] = req_wdata[11:8];
                end
            end
        end
        @(negedge clk);
        chk("R11", 64'(rd_valid), 64'(exp_v));
        chk(exp_tag, rd_data, exp_d);
        for (int k = 0; k < NC; k++)
            chk((tag_ovr != "") ? tag_ovr : "R8", 64'(ovf_flags[k]), 64'(m_ovf[k]));
    endtask

    task automatic req(logic w, logic sp, int idx, logic [63:0] wd, logic [1:0] pl);
        req_valid = 1; req_write = w; req_space = sp; req_idx = 8'(idx);
        req_wdata = wd; priv_lvl = pl;
        tick();
        req_valid = 0; req_write = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);                       // R11 reset state compared each cycle
        rst_n = 1;
        idle(2);
        // R1 R2: program and read back every pair
        req(1, 0, 4, 64'hFFFF_FFFF_FFFF_F103, 0);   // sel 3, mask lvl0
        req(1, 0, 5, 64'h0000_0000_0000_0611, 0);   // sel 17, mask lvl1,2
        req(1, 0, 6, 64'h0000_0000_0000_0FC8, 0);   // sel 200, all levels
        req(1, 0, 7, 64'h0000_0000_0000_08FF, 0);   // sel 255, lvl3
        for (int i = 4; i <= 7; i++) req(0, 0, i, '0, 0);
        // R3: empty slots read zero, writes dropped
        req(0, 0, 0, '0, 0); req(0, 0, 3, '0, 0); req(0, 0, 8, '0, 0);
        req(0, 1, 255, '0, 0); req(0, 1, 2, '0, 0);
        req(1, 0, 8, 64'h0F01, 0); req(1, 1, 3, 64'h55, 0); req(1, 1, 9, 64'h77, 0);
        req(0, 0, 8, '0, 0); req(0, 1, 3, '0, 0);
        for (int i = 4; i <= 7; i++) req(0, 1, i, '0, 0);
        // R4: unprivileged forbidden accesses fault and change nothing
        req(1, 0, 4, 64'h0F55, 1); req(1, 1, 5, 64'h1234, 2);
        req(0, 0, 6, '0, 3); req(1, 1, 200, 64'h1, 3); req(0, 0, 0, '0, 1);
        tag_ovr = "R4";
        req(0, 0, 4, '0, 0); req(0, 1, 5, '0, 0);
        tag_ovr = "";
        // R6: event filtering across levels
        event_bus[3] = 1; event_bus[17] = 1; event_bus[255] = 1;
        priv_lvl = 0; idle(3);
        priv_lvl = 1; idle(2);
        priv_lvl = 2; idle(1);
        priv_lvl = 3; idle(4);
        event_bus = '0;
        tag_ovr = "R6";
        for (int i = 4; i <= 7; i++) req(0, 1, i, '0, 0);
        tag_ovr = "";
        // R5: unprivileged data reads with and without secure masking
        secure_mon = 1; req(0, 1, 5, '0, 2); req(0, 1, 7, '0, 3);
        secure_mon = 0; req(0, 1, 5, '0, 2); req(0, 1, 7, '0, 1);
        // R8: preload near wrap and run into overflow
        req(1, 1, 4, 64'hAAAA_AAAA_FFFF_FFFE, 0);
        event_bus[3] = 1; priv_lvl = 0;
        idle(4);
        event_bus[3] = 0;
        req(0, 1, 4, '0, 0);
        idle(3);
        // R9 R10: write clears flag and wins over a live event
        event_bus[3] = 1;
        tag_ovr = "R10";
        req(1, 1, 4, 64'h10, 0);
        event_bus[3] = 0;
        req(0, 1, 4, '0, 0);
        tag_ovr = "R9";
        idle(1);
        tag_ovr = "";
        // Mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            for (int w = 0; w < 8; w++) event_bus[w*32 +: 32] = $urandom;
            req_valid = ($urandom % 3) != 0;
            req_write = $urandom % 2;
            req_space = $urandom % 2;
            req_idx = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 10);
            req_wdata = {$urandom, $urandom};
            priv_lvl = 2'($urandom);
            secure_mon = $urandom % 2;
            tick();
        end
        req_valid = 0;
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule